// File: doc/BRIEF.md
# Biphasic Stimulus Timer and Driver Selector

This block turns one start trigger into a charge-balanced stimulus: two back-to-back pulses of equal, programmable length. The pulses go to exactly one of four floating output drivers. Each driver has a source-enable line and a sink-enable line. The first pulse opens one of these lines and the second pulse opens the other, so current flows one way and then back. A digital counter takes the place of a capacitor charging to a threshold. The same counter times both pulses, which makes them identical by construction.

The length setting, the driver select and the polarity-swap flag are captured when the trigger is accepted. Changing them during a stimulus therefore has no effect until the next trigger. The block runs only while the wake input is high. Dropping wake aborts any stimulus in progress and blocks new triggers.

All enables come from flip-flops, so the analog switches they drive never see a decode glitch. The enables lag the internal timer by one clock.

Top module: `biphase_stim`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all eight enables (`src_en_o`, `snk_en_o`) are low.
- R2: A trigger sampled high on a rising clock edge with wake high and the block idle starts a stimulus. The first enable goes high two rising edges later and stays high for exactly `dur_i`+1 cycles.
- R3: After the first pulse, all enables are low for exactly one cycle. Then the second pulse is high for the same `dur_i`+1 cycles.
- R4: After the second pulse the block returns to idle, and all enables stay low until a new trigger is accepted. A trigger in the first idle cycle is accepted.
- R5: With `swap_i`=0, the first pulse drives the source enable and the second drives the sink enable. With `swap_i`=1, the first pulse drives the sink enable and the second drives the source enable.
- R6: Only driver number `sel_i` (a binary value 0..3; bit k of each enable bus belongs to driver k) receives pulses. The other drivers' enables stay low.
- R7: A trigger that arrives while a stimulus is active is ignored. The stimulus keeps its original length, driver and polarity.
- R8: When wake is sampled low, all enables are low from two rising edges later. While wake stays low, triggers start nothing.
- R9: No driver has its source and sink enables high in the same cycle, and at most one of the eight enables is high at any time.
- R10: The values of `dur_i`, `sel_i` and `swap_i` are used as sampled at the accepting edge. Changes to them during a stimulus have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Run permission; low aborts the stimulus and blocks triggers |
| trig_i | input | 1 | Start request, sampled on the clock |
| dur_i | input | 8 | Pulse length minus one, in cycles |
| sel_i | input | 2 | Binary index of the driver to use |
| swap_i | input | 1 | Reverses the pulse order (sink first) |
| src_en_o | output | 4 | Source enable, one bit per driver |
| snk_en_o | output | 4 | Sink enable, one bit per driver |

## Verification
A corrupted phase or counter state shows at the ports within one cycle of the registered output stage. It appears as a pulse one cycle too long or too short, as a missing or doubled gap cycle, or as a wrong line or driver lighting up. The bench compares every cycle of each stimulus against the expected pulse pattern, so a single slip in the count fails the check in the cycle it occurs. A polarity or select value that was not held would show as the enable pattern changing inside a pulse. The checker flags that on the next edge, along with any overlap of source and sink enables.

// File: rtl/biphase_pkg.sv
package biphase_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_GAP   = 2'd2,
        PH_SECOND = 2'd3
    } phase_e;
endpackage

// File: rtl/biphase_seq.sv
module biphase_seq
    import biphase_pkg::*;
#(
    parameter int DUR_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_i,
    input  logic             trig_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             swap_i,
    output phase_e           phase_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             swap_o
);
    typedef struct packed {
        phase_e             ph;
        logic [DUR_W-1:0]   cnt;
        logic [DUR_W-1:0]   dur;
        logic [SEL_W-1:0]   sel;
        logic               swap;
    } seq_t;

    seq_t st_d, st_q;
    logic at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = (st_q.cnt == st_q.dur);
        unique case (st_q.ph)
            PH_IDLE: begin
                if (trig_i) begin
                    st_d.ph   = PH_FIRST;
                    st_d.cnt  = '0;
                    st_d.dur  = dur_i;
                    st_d.sel  = sel_i;
                    st_d.swap = swap_i;
                end
            end
            PH_FIRST: begin
                if (at_limit) begin
                    st_d.ph  = PH_GAP;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                st_d.ph = PH_SECOND;
            end
            PH_SECOND: begin
                if (at_limit) begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        if (!wake_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, dur: '0, sel: '0, swap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign sel_o   = st_q.sel;
    assign swap_o  = st_q.swap;
endmodule

// File: rtl/biphase_route.sv
module biphase_route
    import biphase_pkg::*;
#(
    parameter int N_DRV = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             swap_i,
    output logic [N_DRV-1:0] src_en_o,
    output logic [N_DRV-1:0] snk_en_o
);
    typedef struct packed {
        logic [N_DRV-1:0] src;
        logic [N_DRV-1:0] snk;
    } en_t;

    en_t en_d, en_q;
    logic [N_DRV-1:0] hit;
    logic pulse_on;
    logic use_src;

    for (genvar k = 0; k < N_DRV; k++) begin : g_hit
        assign hit[k] = (sel_i == SEL_W'(k));
    end

    always_comb begin
        pulse_on = (phase_i == PH_FIRST) || (phase_i == PH_SECOND);
        use_src  = (phase_i == PH_FIRST) ^ swap_i;
        en_d.src = (pulse_on && use_src)  ? hit : '0;
        en_d.snk = (pulse_on && !use_src) ? hit : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign src_en_o = en_q.src;
    assign snk_en_o = en_q.snk;
endmodule

// File: rtl/biphase_stim.sv
module biphase_stim
    import biphase_pkg::*;
#(
    parameter int DUR_W = 8,
    parameter int N_DRV = 4,
    localparam int SEL_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_i,
    input  logic             trig_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             swap_i,
    output logic [N_DRV-1:0] src_en_o,
    output logic [N_DRV-1:0] snk_en_o
);
    phase_e           phase;
    logic [SEL_W-1:0] sel_q;
    logic             swap_q;

    biphase_seq #(.DUR_W(DUR_W), .SEL_W(SEL_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wake_i (wake_i),
        .trig_i (trig_i),
        .dur_i  (dur_i),
        .sel_i  (sel_i),
        .swap_i (swap_i),
        .phase_o(phase),
        .sel_o  (sel_q),
        .swap_o (swap_q)
    );

    biphase_route #(.N_DRV(N_DRV), .SEL_W(SEL_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .sel_i   (sel_q),
        .swap_i  (swap_q),
        .src_en_o(src_en_o),
        .snk_en_o(snk_en_o)
    );
endmodule

// File: rtl/biphase_stim_chk.sv
module biphase_stim_chk #(
    parameter int N_DRV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_i,
    input logic [N_DRV-1:0] src_en_o,
    input logic [N_DRV-1:0] snk_en_o
);
    logic [2*N_DRV-1:0] en_all;
    assign en_all = {src_en_o, snk_en_o};

    p_one_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_all));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_o & snk_en_o) == '0);

    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_i |=> ##1 (en_all == '0));

    // R6 / R10: inside a pulse the active line never moves to another line
    p_hold_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all != '0) |=> (en_all == '0) || (en_all == $past(en_all)));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (en_all == '0);
        end
    end
endmodule

bind biphase_stim biphase_stim_chk #(.N_DRV(N_DRV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake_i  (wake_i),
    .src_en_o(src_en_o),
    .snk_en_o(snk_en_o)
);

// File: tb/biphase_stim_bench.sv
module biphase_stim_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_i = 1'b0;
    logic       trig_i = 1'b0;
    logic [7:0] dur_i = '0;
    logic [1:0] sel_i = '0;
    logic       swap_i = 1'b0;
    logic [3:0] src_en_o, snk_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    biphase_stim u_biphase_stim (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .trig_i(trig_i),
        .dur_i(dur_i), .sel_i(sel_i), .swap_i(swap_i),
        .src_en_o(src_en_o), .snk_en_o(snk_en_o)
    );

    // vectors: duration setting, driver, swap, expected pulse length
    localparam int NV = 8;
    localparam int VDUR [NV] = '{0, 1, 4, 2, 7, 3, 0, 12};
    localparam int VSEL [NV] = '{0, 1, 2, 3, 0, 3, 2, 1};
    localparam int VSWP [NV] = '{0, 0, 1, 0, 1, 1, 1, 0};
    localparam int VLEN [NV] = '{1, 2, 5, 3, 8, 4, 1, 13};

    task automatic chk(string tag, logic [3:0] es, logic [3:0] ek);
        n_chk++;
        if (src_en_o !== es || snk_en_o !== ek) begin
            n_fail++;
            $display("FAIL %s: src=%b snk=%b expected src=%b snk=%b",
                     tag, src_en_o, snk_en_o, es, ek);
        end
    endtask

    // ph: 0 none, 1 first pulse, 2 second pulse
    task automatic expect_ph(string tag, int ph, int sel, int swp);
        logic [3:0] one;
        logic src_side;
        one = 4'b0001 << sel;
        src_side = (ph == 1) ? (swp == 0) : (swp != 0);
        if (ph == 0) chk(tag, 4'b0, 4'b0);
        else if (src_side) chk(tag, one, 4'b0);
        else chk(tag, 4'b0, one);
    endtask

    // Starts a stimulus at a negedge and checks every cycle up to the first idle one.
    task automatic run_stim(int dur, int sel, int swp, int len, bit disturb);
        dur_i = 8'(dur); sel_i = 2'(sel); swap_i = swp[0]; trig_i = 1'b1;
        @(negedge clk);
        if (disturb) begin
            // R7 R10: retrigger with other settings while active
            trig_i = 1'b1; dur_i = 8'(dur + 9); sel_i = 2'(sel + 1); swap_i = ~swp[0];
        end else begin
            trig_i = 1'b0;
        end
        @(negedge clk);
        trig_i = 1'b0;
        for (int c = 0; c <= 2 * len + 1; c++) begin
            if (c < len) expect_ph("R2 R5 R6 first pulse", 1, sel, swp);
            else if (c == len) expect_ph("R3 gap", 0, sel, swp);
            else if (c <= 2 * len) expect_ph("R3 R5 R6 second pulse", 2, sel, swp);
            else expect_ph("R4 idle after stimulus", 0, sel, swp);
            if (disturb && c == 1) begin
                sel_i = 2'(sel + 2); swap_i = ~swp[0]; dur_i = 8'd200;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 during reset", 4'b0, 4'b0);
        rst_n = 1'b1; wake_i = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 4'b0, 4'b0);

        for (int v = 0; v < NV; v++) begin
            run_stim(VDUR[v], VSEL[v], VSWP[v], VLEN[v], 1'b0);
        end

        // R7 R10: retrigger and setting changes during a stimulus
        run_stim(5, 2, 0, 6, 1'b1);
        run_stim(1, 0, 1, 2, 1'b1);

        // longest setting
        run_stim(255, 3, 1, 256, 1'b0);

        // R4: idle with no trigger stays quiet
        for (int i = 0; i < 4; i++) begin
            expect_ph("R4 quiet without trigger", 0, 0, 0);
            @(negedge clk);
        end

        // R8: wake drop aborts a stimulus
        dur_i = 8'd5; sel_i = 2'd1; swap_i = 1'b0; trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
        @(negedge clk);
        expect_ph("R2 before abort", 1, 1, 0);
        wake_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_ph("R8 abort clears enables", 0, 0, 0);
        trig_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            expect_ph("R8 trigger blocked while asleep", 0, 0, 0);
        end
        trig_i = 1'b0; wake_i = 1'b1;
        @(negedge clk);
        run_stim(2, 2, 1, 3, 1'b0);

        // R1: reset in the middle of a stimulus
        dur_i = 8'd6; sel_i = 2'd3; swap_i = 1'b0; trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid-stimulus", 4'b0, 4'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 quiet after mid reset", 4'b0, 4'b0);
        run_stim(0, 1, 0, 1, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule